// File: doc/BRIEF.md
# Host Read Prefetch Cache

This block is the read side of a display controller's host data port. A control write selects a read target (a memory and a start address). The block does not queue the read behind outstanding writes. It raises one pending flag and waits until the write queue reports empty. It then fetches the first word into a one-word cache before the host asks for it. A host data read is answered from that cache. Each answer advances the address by two and starts the next prefetch. A host read that arrives while the cache is not yet filled is held off until the fill completes.

Three memories can be read. The video memory is byte-wide, so a word takes two byte fetches: the upper half comes first, the lower half second. The colour table and the scroll table are narrower than the 16-bit result. Their unbacked result bits are filled from the stale write-queue entry that the queue presents. When the video address is odd, the cache is declared full after the upper byte alone, and the lower byte keeps its old value.

Top module: `rd_prefetch_cache`

## Requirements
- R1: While a read is pending and `wq_empty` is low, `mem_req` stays low. A fetch begins only on the cycle after `wq_empty` is seen high.
- R2: When a readable target is set up and the write queue is empty, the first word is fetched without any host read request.
- R3: Serving a host read adds 2 to the read address and starts a prefetch of the word at the new address.
- R4: `host_rd_ack` is a one-cycle answer to a held `host_rd_req`, carrying the cache contents on `host_rd_data`. It is withheld while a fetch is pending or in progress, and it is also withheld in any cycle where `setup_valid` is high.
- R5: Target code 2'b00 selects video memory. For an even address, the first fetch is at the address and loads `mem_rdata[7:0]` into result bits [15:8]. The second fetch is at the address with bit 0 set and loads result bits [7:0].
- R6: For an odd video address, only the first fetch is made. The cache becomes valid after it, and result bits [7:0] keep their previous value.
- R7: Target code 2'b01 selects the colour table. Result bits [8:0] come from `mem_rdata[8:0]` and bits [15:9] come from `wq_stale` as sampled in the granted cycle.
- R8: Target code 2'b10 selects the scroll table. Result bits [10:0] come from `mem_rdata[10:0]` and bits [15:11] come from `wq_stale` as sampled in the granted cycle.
- R9: A setup during a pending or in-flight fetch abandons that fetch, discards its data and invalidates the cache. The new target is fetched once the queue is empty.
- R10: Target code 2'b11 selects nothing. No fetch is made, and host reads are answered in the same cycle with the unchanged cache contents, which still advances the address by 2.
- R11: After reset the cache holds 0, the target is code 2'b11 and `mem_req` is low.
- R12: A fetch completes only in a cycle where `mem_req` and `mem_gnt` are both high. Until then `mem_req`, `mem_sel` and `mem_addr` hold steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| setup_valid | input | 1 | Control write that loads a new read target |
| setup_target | input | 2 | Target code: 00 video, 01 colour, 10 scroll, 11 none |
| setup_addr | input | AW | Start byte address |
| wq_empty | input | 1 | Write queue has no pending entries |
| wq_stale | input | 16 | Next write-queue entry (written four writes earlier) |
| host_rd_req | input | 1 | Host data port read, held until acknowledged |
| host_rd_ack | output | 1 | Read answered this cycle |
| host_rd_data | output | 16 | Cache contents returned to the host |
| mem_req | output | 1 | Memory fetch request |
| mem_sel | output | 2 | Memory being fetched (target code) |
| mem_addr | output | AW | Fetch byte address |
| mem_gnt | input | 1 | Memory accepts the fetch; data valid this cycle |
| mem_rdata | input | 16 | Fetched data; video bytes on bits [7:0] |

## Verification
The assertions assume that `host_rd_req`, once raised, stays high until acknowledged. They also assume that `mem_rdata` is valid whenever `mem_gnt` is high with a request open, and that `wq_stale` is meaningful in that same granted cycle. The stimulus changes every input only at the falling clock edge. It drives the memory data from a pure function of `mem_sel` and `mem_addr`, and it puts garbage in the unbacked memory bits so that any leak into the merge is visible. Random phases keep each request high until its acknowledge. Setup writes are thrown into waits, byte fetches and stalled grants, which drives the abort path from every phase.

// File: rtl/rdc_pkg.sv
package rdc_pkg;

    typedef enum logic [1:0] {
        TGT_VID  = 2'b00,
        TGT_COL  = 2'b01,
        TGT_SCR  = 2'b10,
        TGT_NONE = 2'b11
    } tgt_e;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_WAIT = 2'd1,
        PH_HI   = 2'd2,
        PH_LO   = 2'd3
    } ph_e;

endpackage

// File: rtl/rdc_merge.sv
module rdc_merge #(
    parameter int DW     = 16,
    parameter int KEEP_W = 9
) (
    input  logic [DW-1:0] mem_word,
    input  logic [DW-1:0] stale_word,
    output logic [DW-1:0] merged
);
    for (genvar b = 0; b < DW; b++) begin : g_bit
        if (b < KEEP_W) begin : g_mem
            assign merged[b] = mem_word[b];
        end else begin : g_stale
            assign merged[b] = stale_word[b];
        end
    end
endmodule

// File: rtl/rdc_buf.sv
module rdc_buf #(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ld_hi,
    input  logic          ld_lo,
    input  logic          ld_word,
    input  logic [DW-1:0] word_in,
    input  logic [DW/2-1:0] byte_in,
    output logic [DW-1:0] cache_q
);
    localparam int BW = DW / 2;

    typedef struct packed {
        logic [BW-1:0] hi;
        logic [BW-1:0] lo;
    } buf_t;

    buf_t buf_d, buf_q;

    always_comb begin
        buf_d = buf_q;
        if (ld_word) begin
            buf_d = word_in;
        end else begin
            if (ld_hi) buf_d.hi = byte_in;
            if (ld_lo) buf_d.lo = byte_in;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) buf_q <= '0;
        else        buf_q <= buf_d;
    end

    assign cache_q = buf_q;

    // R6
    lo_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_hi && !ld_lo && !ld_word) |=> (cache_q[BW-1:0] == $past(cache_q[BW-1:0])));

    // R5
    hi_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_hi && !ld_word) |=> (cache_q[DW-1:BW] == $past(byte_in)));
endmodule

// File: rtl/rdc_ctrl.sv
module rdc_ctrl
    import rdc_pkg::*;
#(
    parameter int AW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          setup_valid,
    input  logic [1:0]    setup_target,
    input  logic [AW-1:0] setup_addr,
    input  logic          wq_empty,
    input  logic          host_rd_req,
    input  logic          mem_gnt,
    output logic          host_rd_ack,
    output logic          mem_req,
    output logic [1:0]    mem_sel,
    output logic [AW-1:0] mem_addr,
    output logic          ld_hi,
    output logic          ld_lo,
    output logic          ld_word,
    output tgt_e          tgt_o
);
    localparam logic [AW-1:0] STEP_V = AW'(2);
    localparam logic [AW-1:0] ONE_V  = AW'(1);

    typedef struct packed {
        ph_e           ph;
        tgt_e          tgt;
        logic [AW-1:0] addr;
        logic          valid;
    } st_t;

    st_t st_d, st_q;
    logic ack_c;

    always_comb begin
        st_d    = st_q;
        ld_hi   = 1'b0;
        ld_lo   = 1'b0;
        ld_word = 1'b0;
        ack_c   = host_rd_req && !setup_valid && (st_q.ph == PH_IDLE)
                  && (st_q.valid || (st_q.tgt == TGT_NONE));
        if (setup_valid) begin
            st_d.addr  = setup_addr;
            st_d.tgt   = tgt_e'(setup_target);
            st_d.valid = 1'b0;
            st_d.ph    = (tgt_e'(setup_target) == TGT_NONE) ? PH_IDLE : PH_WAIT;
        end else begin
            unique case (st_q.ph)
                PH_IDLE: begin
                    if (ack_c) begin
                        st_d.addr = st_q.addr + STEP_V;
                        if (st_q.tgt != TGT_NONE) begin
                            st_d.valid = 1'b0;
                            st_d.ph    = PH_WAIT;
                        end
                    end
                end
                PH_WAIT: begin
                    if (wq_empty) st_d.ph = PH_HI;
                end
                PH_HI: begin
                    if (mem_gnt) begin
                        if (st_q.tgt == TGT_VID) begin
                            ld_hi = 1'b1;
                            if (st_q.addr[0]) begin
                                st_d.valid = 1'b1;
                                st_d.ph    = PH_IDLE;
                            end else begin
                                st_d.ph = PH_LO;
                            end
                        end else begin
                            ld_word    = 1'b1;
                            st_d.valid = 1'b1;
                            st_d.ph    = PH_IDLE;
                        end
                    end
                end
                PH_LO: begin
                    if (mem_gnt) begin
                        ld_lo      = 1'b1;
                        st_d.valid = 1'b1;
                        st_d.ph    = PH_IDLE;
                    end
                end
                default: st_d.ph = PH_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.ph    <= PH_IDLE;
            st_q.tgt   <= TGT_NONE;
            st_q.addr  <= '0;
            st_q.valid <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign host_rd_ack = ack_c;
    assign mem_req     = (st_q.ph == PH_HI) || (st_q.ph == PH_LO);
    assign mem_sel     = st_q.tgt;
    assign mem_addr    = (st_q.ph == PH_LO) ? (st_q.addr | ONE_V) : st_q.addr;
    assign tgt_o       = st_q.tgt;

    // R1
    fetch_after_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !$past(mem_req)) |-> $past(wq_empty));

    // R4
    no_ack_in_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd_req && mem_req) |-> !host_rd_ack);

    // R9
    setup_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (setup_valid && (setup_target != 2'b11)) |=> !mem_req);

    // R10
    none_no_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd_req && !setup_valid && (tgt_o == TGT_NONE)) |-> host_rd_ack);

    // R12
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_gnt && !setup_valid) |=> (mem_req && $stable(mem_addr) && $stable(mem_sel)));
endmodule

// File: rtl/rd_prefetch_cache.sv
module rd_prefetch_cache
    import rdc_pkg::*;
#(
    parameter int AW    = 16,
    parameter int DW    = 16,
    parameter int COL_W = 9,
    parameter int SCR_W = 11
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          setup_valid,
    input  logic [1:0]    setup_target,
    input  logic [AW-1:0] setup_addr,
    input  logic          wq_empty,
    input  logic [DW-1:0] wq_stale,
    input  logic          host_rd_req,
    output logic          host_rd_ack,
    output logic [DW-1:0] host_rd_data,
    output logic          mem_req,
    output logic [1:0]    mem_sel,
    output logic [AW-1:0] mem_addr,
    input  logic          mem_gnt,
    input  logic [DW-1:0] mem_rdata
);
    localparam int BW = DW / 2;

    logic          ld_hi, ld_lo, ld_word;
    tgt_e          tgt;
    logic [DW-1:0] col_word, scr_word, word_sel, cache_q;

    rdc_ctrl #(.AW(AW)) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .setup_valid  (setup_valid),
        .setup_target (setup_target),
        .setup_addr   (setup_addr),
        .wq_empty     (wq_empty),
        .host_rd_req  (host_rd_req),
        .mem_gnt      (mem_gnt),
        .host_rd_ack  (host_rd_ack),
        .mem_req      (mem_req),
        .mem_sel      (mem_sel),
        .mem_addr     (mem_addr),
        .ld_hi        (ld_hi),
        .ld_lo        (ld_lo),
        .ld_word      (ld_word),
        .tgt_o        (tgt)
    );

    rdc_merge #(.DW(DW), .KEEP_W(COL_W)) u_col_merge (
        .mem_word   (mem_rdata),
        .stale_word (wq_stale),
        .merged     (col_word)
    );

    rdc_merge #(.DW(DW), .KEEP_W(SCR_W)) u_scr_merge (
        .mem_word   (mem_rdata),
        .stale_word (wq_stale),
        .merged     (scr_word)
    );

    assign word_sel = (tgt == TGT_COL) ? col_word : scr_word;

    rdc_buf #(.DW(DW)) u_buf (
        .clk     (clk),
        .rst_n   (rst_n),
        .ld_hi   (ld_hi),
        .ld_lo   (ld_lo),
        .ld_word (ld_word),
        .word_in (word_sel),
        .byte_in (mem_rdata[BW-1:0]),
        .cache_q (cache_q)
    );

    assign host_rd_data = cache_q;

    // R7
    col_stale_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_gnt && !setup_valid && (mem_sel == 2'b01))
        |=> (cache_q[DW-1:COL_W] == $past(wq_stale[DW-1:COL_W])));

    // R8
    scr_stale_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_gnt && !setup_valid && (mem_sel == 2'b10))
        |=> (cache_q[DW-1:SCR_W] == $past(wq_stale[DW-1:SCR_W])));
endmodule

// File: tb/tb_rd_prefetch_cache.sv
module tb_rd_prefetch_cache;
    localparam int AW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          setup_valid = 1'b0;
    logic [1:0]    setup_target = 2'b11;
    logic [AW-1:0] setup_addr = '0;
    logic          wq_empty = 1'b0;
    logic [15:0]   wq_stale = '0;
    logic          host_rd_req = 1'b0;
    logic          host_rd_ack;
    logic [15:0]   host_rd_data;
    logic          mem_req;
    logic [1:0]    mem_sel;
    logic [AW-1:0] mem_addr;
    logic          mem_gnt = 1'b0;
    logic [15:0]   mem_rdata;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done = 0;

    always #4 clk = ~clk;

    function automatic logic [15:0] mem_fn(input logic [1:0] sel, input logic [7:0] a);
        logic [7:0] b;
        b = 8'(a * 8'd5 + 8'h11);
        case (sel)
            2'b00:   return {8'hC3, b};
            2'b01:   return {7'h7F, a ^ 8'h3C, ~a[0]};
            default: return {5'h15, a ^ 8'h5A, 3'b101};
        endcase
    endfunction

    assign mem_rdata = mem_fn(mem_sel, mem_addr);

    rd_prefetch_cache #(.AW(AW)) dut (
        .clk(clk), .rst_n(rst_n),
        .setup_valid(setup_valid), .setup_target(setup_target), .setup_addr(setup_addr),
        .wq_empty(wq_empty), .wq_stale(wq_stale),
        .host_rd_req(host_rd_req), .host_rd_ack(host_rd_ack), .host_rd_data(host_rd_data),
        .mem_req(mem_req), .mem_sel(mem_sel), .mem_addr(mem_addr),
        .mem_gnt(mem_gnt), .mem_rdata(mem_rdata)
    );

    // reference model state
    int          m_step = 0;      // 0 idle, 1 waiting on queue, 2 first fetch, 3 second fetch
    logic [1:0]  m_tgt = 2'b11;
    logic [7:0]  m_addr = '0;
    bit          m_full = 0;
    logic [15:0] m_cache = '0;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h (cycle %0d)", tag, act, exp, cycles);
        end
    endtask

    function automatic string data_tag();
        if (m_tgt == 2'b11) return "R10";
        if (m_tgt == 2'b01) return "R7";
        if (m_tgt == 2'b10) return "R8";
        if (m_addr[0])      return "R6";
        return "R5";
    endfunction

    task automatic step(input bit sv, input logic [1:0] st, input logic [7:0] sa,
                        input bit rq, input bit we, input bit gn, input logic [15:0] stl);
        bit         e_req, e_ack;
        logic [7:0] e_addr;
        logic [15:0] rd, mask;
        @(negedge clk);
        cycles++;
        setup_valid = sv; setup_target = st; setup_addr = sa;
        host_rd_req = rq; wq_empty = we; mem_gnt = gn; wq_stale = stl;
        #1;
        e_req  = (m_step == 2) || (m_step == 3);
        e_addr = (m_step == 3) ? (m_addr | 8'h01) : m_addr;
        e_ack  = rq && !sv && (m_step == 0) && (m_full || m_tgt == 2'b11);
        chk((m_step == 1) ? "R1" : "R2", 32'(mem_req), 32'(e_req));
        if (e_req) begin
            chk("R12", 32'(mem_addr), 32'(e_addr));
            chk("R12", 32'(mem_sel), 32'(m_tgt));
        end
        chk("R4", 32'(host_rd_ack), 32'(e_ack));
        if (e_ack && host_rd_ack) chk(data_tag(), 32'(host_rd_data), 32'(m_cache));
        // advance the model to the next rising edge
        if (sv) begin
            m_addr = sa; m_tgt = st; m_full = 0;
            m_step = (st == 2'b11) ? 0 : 1;
        end else begin
            case (m_step)
                0: if (e_ack) begin
                       m_addr = m_addr + 8'd2;
                       if (m_tgt != 2'b11) begin m_full = 0; m_step = 1; end
                   end
                1: if (we) m_step = 2;
                2: if (gn) begin
                       rd = mem_fn(m_tgt, e_addr);
                       if (m_tgt == 2'b00) begin
                           m_cache[15:8] = rd[7:0];
                           if (m_addr[0]) begin m_full = 1; m_step = 0; end
                           else m_step = 3;
                       end else begin
                           mask = (m_tgt == 2'b01) ? 16'h01FF : 16'h07FF;
                           m_cache = (rd & mask) | (stl & ~mask);
                           m_full = 1; m_step = 0;
                       end
                   end
                3: if (gn) begin
                       rd = mem_fn(m_tgt, e_addr);
                       m_cache[7:0] = rd[7:0];
                       m_full = 1; m_step = 0;
                   end
                default: m_step = 0;
            endcase
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [15:0] hold_hi;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R11 / R10: reset state, no target, read answered at once with 0
        step(0, 2'b11, 8'h00, 1, 1, 1, 16'h0);
        chk("R11", 32'(host_rd_data), 32'h0);
        chk("R11", 32'(mem_req), 32'h0);

        // R1 / R4: video even target while the queue drains; host read stalls
        step(1, 2'b00, 8'h10, 0, 0, 1, 16'h0);
        for (int i = 0; i < 5; i++) step(0, 2'b00, 8'h00, 1, 0, 1, 16'h0);
        for (int i = 0; i < 4; i++) step(0, 2'b00, 8'h00, 1, 1, 1, 16'h0);
        // R3: after the answer the next prefetch targets 0x12
        step(0, 2'b00, 8'h00, 0, 1, 0, 16'h0);
        step(0, 2'b00, 8'h00, 0, 1, 0, 16'h0);
        chk("R3", 32'(mem_addr), 32'h12);
        chk("R3", 32'(mem_req), 32'h1);
        for (int i = 0; i < 4; i++) step(0, 2'b00, 8'h00, 0, 1, 1, 16'h0);
        step(0, 2'b00, 8'h00, 1, 1, 1, 16'h0);

        // R6: odd video address keeps the lower byte
        hold_hi = host_rd_data;
        step(1, 2'b00, 8'h21, 0, 1, 1, 16'h0);
        for (int i = 0; i < 4; i++) step(0, 2'b00, 8'h00, 0, 1, 1, 16'h0);
        step(0, 2'b00, 8'h00, 1, 1, 1, 16'h0);
        chk("R6", 32'(host_rd_data[7:0]), 32'(hold_hi[7:0]));

        // R7: colour table with a stale queue entry
        step(1, 2'b01, 8'h40, 0, 1, 1, 16'hABCD);
        for (int i = 0; i < 4; i++) step(0, 2'b00, 8'h00, 0, 1, 1, 16'hABCD);
        step(0, 2'b00, 8'h00, 1, 1, 1, 16'h0);
        chk("R7", 32'(host_rd_data[15:9]), 32'(7'h55));

        // R8: scroll table
        step(1, 2'b10, 8'h52, 0, 1, 1, 16'h9876);
        for (int i = 0; i < 4; i++) step(0, 2'b00, 8'h00, 0, 1, 1, 16'h9876);
        step(0, 2'b00, 8'h00, 1, 1, 1, 16'h0);
        chk("R8", 32'(host_rd_data[15:11]), 32'(5'h13));

        // R9: setup during a stalled fetch abandons it
        step(1, 2'b00, 8'h60, 0, 1, 0, 16'h0);
        step(0, 2'b00, 8'h00, 0, 1, 0, 16'h0);
        step(0, 2'b00, 8'h00, 0, 1, 0, 16'h0);
        step(1, 2'b01, 8'h70, 1, 0, 1, 16'h1234);
        step(0, 2'b00, 8'h00, 1, 0, 1, 16'h1234);
        chk("R9", 32'(mem_req), 32'h0);
        chk("R9", 32'(host_rd_ack), 32'h0);
        for (int i = 0; i < 4; i++) step(0, 2'b00, 8'h00, 1, 1, 1, 16'h1234);

        // R10: unreadable target answers without fetching
        step(1, 2'b11, 8'h80, 0, 1, 1, 16'h0);
        step(0, 2'b00, 8'h00, 1, 0, 1, 16'h0);
        step(0, 2'b00, 8'h00, 1, 0, 1, 16'h0);

        // mixed random traffic; a request is held until answered
        begin
            bit rq = 0;
            for (int i = 0; i < 4000; i++) begin
                bit sv;
                sv = ($urandom_range(0, 24) == 0);
                if (!rq) rq = ($urandom_range(0, 3) == 0);
                step(sv, 2'($urandom_range(0, 3)), 8'($urandom_range(0, 255)), rq,
                     ($urandom_range(0, 2) != 0), ($urandom_range(0, 2) != 0),
                     16'($urandom_range(0, 65535)));
                if (host_rd_ack) rq = 0;
            end
        end
        finish_run();
    end
endmodule